// File: doc/BRIEF.md
# Flash Card Configuration Register and Page Control

This block sits between a host bus and the flash array of a removable linear flash memory card. It holds two small registers in attribute space: an option register with a soft-reset bit and a two-bit page field, and a status register with a power-down bit. From those registers it drives the upper address bits of the array, an array enable, and a power-down request to every memory device.

Common-memory accesses use a 64 MB direct byte address. The page field sits above that address, so the array is extended in 64 MB steps. Page codes 0, 1 and 2 reach memory. Code 3 reaches nothing. Soft reset, the power-down bit and the hardware reset all hold the array powered down and block every array access. A blocked read returns zero.

The bus is synchronous. Reads return one cycle after the read strobe, flagged by a valid pulse. Writes take effect at the clock edge that samples the strobe.

Top module: `flashcard_cfg_ctrl`

## Requirements
- R1: The option register is at attribute address 0x4000 and the status register is at 0x4002. Both can be read and written. The option register reads back soft reset in bit 7 and the page in bits 1:0. The status register reads back power-down in bit 2. `rd_valid` is high, with `rd_data`, in the cycle after every read strobe.
- R2: A write of bit 7 = 1 to the option register enters soft reset. From the next cycle `array_pd` is high, `page_sel` is 0 and the power-down bit is 0.
- R3: While soft reset is active, the other bits of an option write are ignored. An option write with bit 7 = 0 ends soft reset and leaves page 0 and power-down 0, whatever bits 1:0 hold.
- R4: Outside soft reset, an option write with bit 7 = 0 loads bits 1:0 of the write data into the page field.
- R5: `page_sel` always shows the current page field, which forms the array address bits above the 64 MB direct range.
- R6: With page code 3 selected, a common-memory access asserts no `array_en`, and a read returns 0.
- R7: Writing 1 to status bit 2 raises `array_pd` and blocks the array. Writing 0 returns the array to standby. Status writes are ignored during soft reset.
- R8: `hw_rst` is active high and asynchronous. It clears soft reset, page and power-down to 0. While it is asserted, `array_pd` is high and `array_en` is low.
- R9: `array_en` is high only for a common-memory access (`attr_n` = 1 with a read or write strobe) when no power-down source is active and the page is not 3. Attribute accesses never assert it.
- R10: A common read with the array enabled returns `mem_rdata` from the strobe cycle. A blocked common read returns 0.
- R11: Option bits 6:2, status bits other than 2, and all bits above 7 read as 0. Writes to them are ignored.
- R12: Attribute reads at any other address return 0, and attribute writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hw_rst | input | 1 | Hardware reset, active high, asynchronous |
| bus_addr | input | 26 | Byte address (direct 64 MB range or attribute offset) |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| attr_n | input | 1 | Low selects attribute space, high selects common memory |
| mem_rdata | input | 16 | Read data returned by the flash array |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| page_sel | output | 2 | Array address bits above the direct range |
| array_en | output | 1 | Enable to the devices of the array |
| array_pd | output | 1 | Reset/power-down request to every device |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that an access lasts exactly one cycle, so a stable strobe means a new access. `mem_rdata` is assumed to answer within the strobe cycle. The bench drives every access as a single-cycle pulse on the falling edge and returns to idle between accesses. Its array model returns data that depends only on the current page and the address, so it always answers within that cycle.

// File: rtl/flashcard_cfg_ctrl.sv
module flashcard_cfg_ctrl #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 2,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h4000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h4002,
  parameter int SRST_BIT = 7,
  parameter int PD_BIT   = 2
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              attr_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [PAGE_W-1:0] page_sel,
  output logic              array_en,
  output logic              array_pd
);

  localparam logic [PAGE_W-1:0] BLK_PAGE = {PAGE_W{1'b1}};

  logic              srst_q;
  logic              pd_q;
  logic [PAGE_W-1:0] page_q;

  logic opt_wr, stat_wr, opt_rd, stat_rd, mem_acc;
  logic [DATA_W-1:0] opt_view, stat_view, rd_next;

  assign opt_wr  = bus_wr & ~attr_n & (bus_addr == OPT_ADDR);
  assign stat_wr = bus_wr & ~attr_n & (bus_addr == STAT_ADDR);
  assign opt_rd  = bus_rd & ~attr_n & (bus_addr == OPT_ADDR);
  assign stat_rd = bus_rd & ~attr_n & (bus_addr == STAT_ADDR);
  assign mem_acc = (bus_wr | bus_rd) & attr_n;

  assign array_pd = hw_rst | srst_q | pd_q;
  assign array_en = mem_acc & ~array_pd & (page_q != BLK_PAGE);
  assign page_sel = page_q;

  always_comb begin
    opt_view = '0;
    opt_view[SRST_BIT] = srst_q;
    opt_view[PAGE_W-1:0] = page_q;
    stat_view = '0;
    stat_view[PD_BIT] = pd_q;
  end

  always_comb begin
    rd_next = '0;
    if (opt_rd)
      rd_next = opt_view;
    else if (stat_rd)
      rd_next = stat_view;
    else if (bus_rd && array_en)
      rd_next = mem_rdata;
  end

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      srst_q <= 1'b0;
      page_q <= '0;
      pd_q   <= 1'b0;
    end else if (opt_wr) begin
      if (bus_wdata[SRST_BIT]) begin
        srst_q <= 1'b1;
        page_q <= '0;
        pd_q   <= 1'b0;
      end else if (srst_q) begin
        srst_q <= 1'b0;
        page_q <= '0;
        pd_q   <= 1'b0;
      end else begin
        page_q <= bus_wdata[PAGE_W-1:0];
      end
    end else if (stat_wr && !srst_q) begin
      pd_q <= bus_wdata[PD_BIT];
    end
  end

  always_ff @(posedge clk or posedge hw_rst) begin
    if (hw_rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      rd_data  <= bus_rd ? rd_next : '0;
    end
  end

  // Input assumption: strobes are exclusive
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (hw_rst)
    !(bus_wr && bus_rd));

  p_rd_valid_r1: assert property (@(posedge clk) disable iff (hw_rst)
    bus_rd |=> rd_valid);

  p_srst_enter_r2: assert property (@(posedge clk) disable iff (hw_rst)
    (opt_wr && bus_wdata[SRST_BIT]) |=> (array_pd && page_sel == '0 && !pd_q));

  p_srst_exit_r3: assert property (@(posedge clk) disable iff (hw_rst)
    (srst_q && opt_wr && !bus_wdata[SRST_BIT]) |=> (!srst_q && page_sel == '0 && !pd_q));

  p_page_load_r4: assert property (@(posedge clk) disable iff (hw_rst)
    (!srst_q && opt_wr && !bus_wdata[SRST_BIT]) |=> (page_sel == $past(bus_wdata[PAGE_W-1:0])));

  p_blocked_read_r6: assert property (@(posedge clk) disable iff (hw_rst)
    (bus_rd && attr_n && (page_q == BLK_PAGE || array_pd)) |=> (rd_valid && rd_data == '0));

  p_stat_locked_r7: assert property (@(posedge clk) disable iff (hw_rst)
    (srst_q && stat_wr) |=> !pd_q);

  p_attr_no_en_r9: assert property (@(posedge clk) disable iff (hw_rst)
    !attr_n |-> !array_en);

endmodule

// File: tb/flashcard_cfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module flashcard_cfg_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        hw_rst = 1'b1;
  logic [25:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, attr_n = 1'b1;
  logic [15:0] mem_rdata, rd_data;
  logic        rd_valid, array_en, array_pd;
  logic [1:0]  page_sel;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  assign mem_rdata = {page_sel, bus_addr[13:0]};

  flashcard_cfg_ctrl dut_i (
    .clk(clk), .hw_rst(hw_rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .attr_n(attr_n), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .page_sel(page_sel),
    .array_en(array_en), .array_pd(array_pd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!hw_rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected read", 16'h1, 16'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic op(input logic w, input logic r, input logic an,
                    input logic [25:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; attr_n = an; bus_addr = a; bus_wdata = d;
    #2;
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b1, 26'h0, 16'h0);
  endtask

  task automatic awr(input logic [25:0] a, input logic [15:0] d);
    op(1'b1, 1'b0, 1'b0, a, d);
  endtask

  task automatic ard(input logic [25:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    op(1'b0, 1'b1, 1'b0, a, 16'h0);
  endtask

  task automatic mrd(input logic [25:0] a, input logic [15:0] e, input logic en, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    op(1'b0, 1'b1, 1'b1, a, 16'h0);
    chk({t, " enable"}, {15'h0, array_en}, {15'h0, en});
  endtask

  initial begin
    #(20 * 200000);
    chk("watchdog", 16'h1, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3;
    chk("R8 pd in reset", {15'h0, array_pd}, 16'h1);
    chk("R8 page in reset", {14'h0, page_sel}, 16'h0);
    chk("R8 no valid in reset", {15'h0, rd_valid}, 16'h0);
    @(negedge clk); hw_rst = 1'b0;
    idle();
    chk("R8 pd released", {15'h0, array_pd}, 16'h0);

    ard(26'h4000, 16'h0000, "R1 option default");
    ard(26'h4002, 16'h0000, "R1 status default");
    awr(26'h4000, 16'h0001);
    idle();
    chk("R5 page 1", {14'h0, page_sel}, 16'h1);
    ard(26'h4000, 16'h0001, "R4 page load");
    mrd(26'h0123, 16'h4123, 1'b1, "R10 page1 read");
    op(1'b1, 1'b0, 1'b1, 26'h0456, 16'hBEEF);
    chk("R9 common write en", {15'h0, array_en}, 16'h1);
    ard(26'h4000, 16'h0001, "R9 bus not disturbed");
    chk("R9 attr read no en", {15'h0, array_en}, 16'h0);

    awr(26'h4000, 16'hFF7E);
    ard(26'h4000, 16'h0002, "R11 option reserved");
    mrd(26'h0ABC, 16'h8ABC, 1'b1, "R10 page2 read");
    awr(26'h4000, 16'h0003);
    ard(26'h4000, 16'h0003, "R4 page3 load");
    mrd(26'h0010, 16'h0000, 1'b0, "R6 page3 read");
    op(1'b1, 1'b0, 1'b1, 26'h0010, 16'h1234);
    chk("R6 page3 write en", {15'h0, array_en}, 16'h0);

    awr(26'h4000, 16'h0000);
    awr(26'h4002, 16'hFFFF);
    idle();
    chk("R7 pd raised", {15'h0, array_pd}, 16'h1);
    ard(26'h4002, 16'h0004, "R11 status reserved");
    mrd(26'h0020, 16'h0000, 1'b0, "R7 powered-down read");
    awr(26'h4002, 16'h0000);
    idle();
    chk("R7 standby", {15'h0, array_pd}, 16'h0);
    mrd(26'h0021, 16'h0021, 1'b1, "R10 page0 read");

    awr(26'h4000, 16'h0002);
    awr(26'h4000, 16'h0081);
    idle();
    chk("R2 srst pd", {15'h0, array_pd}, 16'h1);
    chk("R2 srst page", {14'h0, page_sel}, 16'h0);
    ard(26'h4000, 16'h0080, "R2 srst readback");
    mrd(26'h0030, 16'h0000, 1'b0, "R2 srst blocks read");
    awr(26'h4002, 16'h0004);
    ard(26'h4002, 16'h0000, "R7 status locked in srst");
    awr(26'h4000, 16'h0082);
    ard(26'h4000, 16'h0080, "R3 page ignored in srst");
    awr(26'h4000, 16'h0003);
    idle();
    chk("R3 exit pd", {15'h0, array_pd}, 16'h0);
    ard(26'h4000, 16'h0000, "R3 exit defaults");

    awr(26'h4004, 16'h0003);
    ard(26'h4000, 16'h0000, "R12 stray write no effect");
    ard(26'h4004, 16'h0000, "R12 stray read zero");

    awr(26'h4000, 16'h0002);
    awr(26'h4002, 16'h0004);
    @(negedge clk); hw_rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; attr_n = 1'b1;
    #2;
    chk("R8 hw reset pd", {15'h0, array_pd}, 16'h1);
    op(1'b0, 1'b1, 1'b1, 26'h0040, 16'h0);
    chk("R8 hw reset no en", {15'h0, array_en}, 16'h0);
    @(negedge clk); hw_rst = 1'b0; bus_rd = 1'b0;
    idle();
    ard(26'h4000, 16'h0000, "R8 option cleared");
    ard(26'h4002, 16'h0000, "R8 status cleared");
    idle(); idle(); idle();
    chk("R1 all reads returned", 16'(exp_q.size()), 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule